// File: doc/BRIEF.md
# Dual-Mode CAN Interrupt and Status Controller

This block holds the interrupt flags, the status bits and the command decoding of a CAN controller that runs in one of two register personalities: a basic mode and an extended mode. Each mode has its own interrupt flag register and its own status register. A mode bit in the clock-divider register selects which pair is live. Events from the receive and transmit paths update the live pair. These events are a frame accepted, a frame dropped by overrun and a transmission finished. Register writes (command, enable, control, clock divider) and a read of the interrupt register also act on the live pair.

A single level-sensitive interrupt line is recomputed every cycle from the live flags and the enables of the live mode, and it is registered. The extended mode uses a dedicated enable register. The basic mode takes its enables from the control register shifted right by one bit. Reading the interrupt register returns the flags and clears them. The receive flag comes straight back while the frame store still reports pending messages.

Mode selection is a two-state machine. In state `MODE_BASIC`, a write to the clock divider with bit 7 set takes the transition to `MODE_EXT`. In state `MODE_EXT`, a write to the clock divider with bit 7 clear takes the transition back to `MODE_BASIC`. Every other input leaves the state where it is.

Top module: `canirq_core`

## Requirements
- R1: After reset both flag registers and both status registers read 0, the mode is basic, the control, enable and clock-divider registers read 0, and `irq` is low.
- R2: Register addresses are control 0, command 1, status 2, interrupt 3, enable 4 and clock divider 5. Bit 7 of the clock divider selects extended mode when 1. Events, commands and interrupt reads change only the active mode's flags and status. Reads at addresses 2 and 3 show the active mode's copy, and the inactive copy keeps its value across mode changes.
- R3: In extended mode `irq` is high exactly when (enable register AND interrupt flags) is nonzero.
- R4: In basic mode `irq` is high exactly when ((control >> 1) AND interrupt flags) is nonzero. Control bit 1 enables receive, bit 2 enables transmit and bit 4 enables overrun.
- R5: `irq` is registered. It reflects the flags and enables one clock after they change, and this includes a write to the enable, control or clock-divider register.
- R6: A frame-accepted event sets flag bit 0 (receive) and status bit 0 (buffer full), and clears status bit 4 (receiving).
- R7: A transmit-complete event sets flag bit 1 (transmit) and clears status bit 5 (transmit status).
- R8: An overrun event sets flag bit 3 (overrun) and status bit 1 (overrun), and clears status bit 4.
- R9: Writing command bit 2 (release) with a pending count of 0 or above 1 leaves the flags and status unchanged. With a pending count of 1 it clears status bit 0 and flag bit 0.
- R10: Writing command bit 3 clears status bit 1 and flag bit 3.
- R11: A read of address 3 returns the current flags. All flags then clear, and flag bit 0 is set again if the pending count is nonzero.
- R12: An event that arrives in the same cycle as a read-clear, a release or an overrun clear wins, and its flag is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect only at address 3) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| ev_rx | input | 1 | Frame accepted into the receive store |
| ev_ovr | input | 1 | Frame dropped because the store was full |
| ev_tx | input | 1 | Transmission completed |
| rx_pending | input | PEND_W | Messages currently held in the receive store |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The interrupt equation is swept in both modes over every combination of the three enables and every combination of the three events. This separates the extended enable register from the shifted control register, and it shows whether each flag is routed to its own enable bit. The same sweep checks that the line stays low for one clock after the flags change. Directed sequences drive release commands with pending counts 0, 1 and 2 to separate the "ignored" and "last message" cases. Read-clears run with zero and nonzero pending counts. Collisions between an event and a clear in the same cycle show which side wins. Switches between modes show that the two flag copies stay separate.

// File: rtl/canirq_pkg.sv
package canirq_pkg;
    localparam int REG_W = 8;

    // register addresses
    localparam int A_CTRL = 0;
    localparam int A_CMD  = 1;
    localparam int A_STAT = 2;
    localparam int A_INTR = 3;
    localparam int A_IEN  = 4;
    localparam int A_CDIV = 5;

    // interrupt flag positions
    localparam int FL_RX  = 0;
    localparam int FL_TX  = 1;
    localparam int FL_OVR = 3;

    // status positions
    localparam int ST_RXFULL = 0;
    localparam int ST_OVR    = 1;
    localparam int ST_RXING  = 4;
    localparam int ST_TXST   = 5;

    // command bits and mode bit
    localparam int CMD_RELEASE = 2;
    localparam int CMD_CLROVR  = 3;
    localparam int CDIV_EXT    = 7;

    typedef enum logic {
        MODE_BASIC = 1'b0,
        MODE_EXT   = 1'b1
    } mode_e;

    typedef struct packed {
        logic rx;
        logic tx;
        logic ovr;
    } ev_t;
endpackage

// File: rtl/canirq_regs.sv
module canirq_regs
    import canirq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  ctrl_q,
    output logic [REG_W-1:0]  ien_q,
    output logic [REG_W-1:0]  cdiv_q,
    output mode_e             mode,
    output logic              cmd_release,
    output logic              cmd_clr_ovr
);
    mode_e mode_q, mode_d;
    logic  cdiv_wr;

    assign cdiv_wr = wr && (addr == ADDR_W'(A_CDIV));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_BASIC;
        else        mode_q <= mode_d;
    end

    // next state
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_BASIC: if (cdiv_wr && wdata[CDIV_EXT])  mode_d = MODE_EXT;
            MODE_EXT:   if (cdiv_wr && !wdata[CDIV_EXT]) mode_d = MODE_BASIC;
        endcase
    end

    // outputs
    always_comb begin
        mode        = mode_q;
        cmd_release = wr && (addr == ADDR_W'(A_CMD)) && wdata[CMD_RELEASE];
        cmd_clr_ovr = wr && (addr == ADDR_W'(A_CMD)) && wdata[CMD_CLROVR];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ien_q  <= '0;
            cdiv_q <= '0;
        end else if (wr) begin
            if (addr == ADDR_W'(A_CTRL)) ctrl_q <= wdata;
            if (addr == ADDR_W'(A_IEN))  ien_q  <= wdata;
            if (addr == ADDR_W'(A_CDIV)) cdiv_q <= wdata;
        end
    end

    assert_mode_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cdiv_wr |=> (mode_q == ($past(wdata[CDIV_EXT]) ? MODE_EXT : MODE_BASIC)));
endmodule

// File: rtl/canirq_flagbank.sv
module canirq_flagbank
    import canirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  ev_t              ev,
    input  logic             cmd_release,
    input  logic             cmd_clr_ovr,
    input  logic             rd_clr,
    input  logic             pend_nz,
    input  logic             pend_one,
    output logic [REG_W-1:0] flag_q,
    output logic [REG_W-1:0] stat_q
);
    logic [REG_W-1:0] flag_d, stat_d;

    // clears first, events last, so an event in the same cycle wins
    always_comb begin
        flag_d = flag_q;
        stat_d = stat_q;
        if (active) begin
            if (rd_clr) begin
                flag_d = '0;
                if (pend_nz) flag_d[FL_RX] = 1'b1;
            end
            if (cmd_release && pend_nz && pend_one) begin
                stat_d[ST_RXFULL] = 1'b0;
                flag_d[FL_RX]     = 1'b0;
            end
            if (cmd_clr_ovr) begin
                stat_d[ST_OVR] = 1'b0;
                flag_d[FL_OVR] = 1'b0;
            end
            if (ev.tx) begin
                stat_d[ST_TXST] = 1'b0;
                flag_d[FL_TX]   = 1'b1;
            end
            if (ev.rx) begin
                stat_d[ST_RXFULL] = 1'b1;
                stat_d[ST_RXING]  = 1'b0;
                flag_d[FL_RX]     = 1'b1;
            end
            if (ev.ovr) begin
                stat_d[ST_OVR]   = 1'b1;
                stat_d[ST_RXING] = 1'b0;
                flag_d[FL_OVR]   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            stat_q <= '0;
        end else begin
            flag_q <= flag_d;
            stat_q <= stat_d;
        end
    end

    assert_idle_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ($stable(flag_q) && $stable(stat_q)));
    assert_rx_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ev.rx) |=> (flag_q[FL_RX] && stat_q[ST_RXFULL] && !stat_q[ST_RXING]));
    assert_tx_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ev.tx) |=> (flag_q[FL_TX] && !stat_q[ST_TXST]));
    assert_ovr_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ev.ovr) |=> (flag_q[FL_OVR] && stat_q[ST_OVR]));
    assert_release_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cmd_release && !pend_nz && !rd_clr && !ev.rx) |=> $stable(flag_q[FL_RX]));
    assert_clear_ovr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cmd_clr_ovr && !ev.ovr) |=> (!flag_q[FL_OVR] && !stat_q[ST_OVR]));
    assert_read_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rd_clr && !pend_nz && !ev.rx && !ev.tx && !ev.ovr) |=> (flag_q == '0));
    assert_read_refill_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rd_clr && pend_nz && !cmd_release) |=> flag_q[FL_RX]);
    assert_event_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rd_clr && ev.tx) |=> flag_q[FL_TX]);
endmodule

// File: rtl/canirq_irqgen.sv
module canirq_irqgen
    import canirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic [REG_W-1:0] ien,
    input  logic [REG_W-1:0] ctrl,
    input  logic [REG_W-1:0] flags,
    output logic             irq
);
    logic [REG_W-1:0] en_sel;
    logic             level;

    always_comb begin
        unique case (mode)
            MODE_EXT:   en_sel = ien;
            MODE_BASIC: en_sel = ctrl >> 1;
        endcase
        level = |(en_sel & flags);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= level;
    end

    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(level));
    assert_irq_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flags) == '0) |-> !irq);
endmodule

// File: rtl/canirq_core.sv
module canirq_core
    import canirq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int PEND_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ev_rx,
    input  logic              ev_ovr,
    input  logic              ev_tx,
    input  logic [PEND_W-1:0] rx_pending,
    output logic              irq
);
    localparam int N_BANK = 2;

    logic [REG_W-1:0] ctrl_q, ien_q, cdiv_q;
    mode_e            mode;
    logic             cmd_release, cmd_clr_ovr, rd_clr, pend_nz, pend_one;
    ev_t              ev;
    logic [REG_W-1:0] flag_b [N_BANK];
    logic [REG_W-1:0] stat_b [N_BANK];
    logic [REG_W-1:0] flag_act, stat_act;

    assign ev       = '{rx: ev_rx, tx: ev_tx, ovr: ev_ovr};
    assign rd_clr   = bus_rd && (bus_addr == ADDR_W'(A_INTR));
    assign pend_nz  = |rx_pending;
    assign pend_one = (rx_pending == PEND_W'(1));

    canirq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .ctrl_q(ctrl_q), .ien_q(ien_q), .cdiv_q(cdiv_q), .mode(mode),
        .cmd_release(cmd_release), .cmd_clr_ovr(cmd_clr_ovr)
    );

    for (genvar g = 0; g < N_BANK; g++) begin : g_bank
        canirq_flagbank u_bank (
            .clk(clk), .rst_n(rst_n),
            .active(mode == ((g == 1) ? MODE_EXT : MODE_BASIC)),
            .ev(ev), .cmd_release(cmd_release), .cmd_clr_ovr(cmd_clr_ovr),
            .rd_clr(rd_clr), .pend_nz(pend_nz), .pend_one(pend_one),
            .flag_q(flag_b[g]), .stat_q(stat_b[g])
        );
    end

    assign flag_act = (mode == MODE_EXT) ? flag_b[1] : flag_b[0];
    assign stat_act = (mode == MODE_EXT) ? stat_b[1] : stat_b[0];

    canirq_irqgen u_irq (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ien(ien_q), .ctrl(ctrl_q),
        .flags(flag_act), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        if      (bus_addr == ADDR_W'(A_CTRL)) bus_rdata = ctrl_q;
        else if (bus_addr == ADDR_W'(A_STAT)) bus_rdata = stat_act;
        else if (bus_addr == ADDR_W'(A_INTR)) bus_rdata = flag_act;
        else if (bus_addr == ADDR_W'(A_IEN))  bus_rdata = ien_q;
        else if (bus_addr == ADDR_W'(A_CDIV)) bus_rdata = cdiv_q;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!irq && (flag_act == '0) && (mode == MODE_BASIC)));
endmodule

// File: tb/canirq_core_test.sv
module canirq_core_test;
    import canirq_pkg::*;
    localparam int ADDR_W = 3;
    localparam int PEND_W = 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              ev_rx = 1'b0, ev_ovr = 1'b0, ev_tx = 1'b0;
    logic [PEND_W-1:0] rx_pending = '0;
    logic              irq;
    int                n_chk = 0, n_bad = 0;
    bit                done = 1'b0;

    always #10 clk = ~clk;

    canirq_core #(.ADDR_W(ADDR_W), .PEND_W(PEND_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_rx(ev_rx), .ev_ovr(ev_ovr), .ev_tx(ev_tx),
        .rx_pending(rx_pending), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdclr(output logic [7:0] v);
        bus_addr = ADDR_W'(A_INTR); bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic rx, input logic tx, input logic ovr);
        ev_rx = rx; ev_tx = tx; ev_ovr = ovr;
        @(negedge clk);
        ev_rx = 1'b0; ev_tx = 1'b0; ev_ovr = 1'b0;
    endtask

    task automatic peek(input int a, output logic [7:0] v);
        bus_addr = ADDR_W'(a);
        #1 v = bus_rdata;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "irq", {7'b0, irq}, 8'h00);
        peek(A_INTR, v); check("R1", "flags", v, 8'h00);
        peek(A_STAT, v); check("R1", "status", v, 8'h00);
        peek(A_CDIV, v); check("R1", "clkdiv", v, 8'h00);
        peek(A_CTRL, v); check("R1", "ctrl", v, 8'h00);
        peek(A_IEN, v);  check("R1", "ien", v, 8'h00);

        // sweep: mode x enable set x event set (R3 R4 R5 R6 R7 R8)
        for (int m = 0; m < 2; m++) begin
            wr(A_CDIV, (m == 1) ? 8'h80 : 8'h00);
            for (int e = 0; e < 8; e++) begin
                logic [7:0] enm;
                enm = {4'b0, e[2], 1'b0, e[1], e[0]};
                if (m == 1) wr(A_IEN, enm);
                else        wr(A_CTRL, enm << 1);
                for (int k = 0; k < 8; k++) begin
                    logic [7:0] fm;
                    fm = {4'b0, k[2], 1'b0, k[1], k[0]};
                    rdclr(v);
                    pulse(k[0], k[1], k[2]);
                    check("R5", "irq one cycle after flag change", {7'b0, irq}, 8'h00);
                    peek(A_INTR, v);
                    check("R6/R7/R8", "event flags", v, fm);
                    @(negedge clk);
                    check((m == 1) ? "R3" : "R4", "irq level",
                          {7'b0, irq}, {7'b0, |(fm & enm)});
                end
            end
        end

        // now extended mode, ien=0x0b, both banks hold flags 0x0b
        rx_pending = '0;
        rdclr(v); check("R11", "read returns flags", v, 8'h0b);
        peek(A_INTR, v); check("R11", "flags cleared", v, 8'h00);
        peek(A_STAT, v); check("R6/R8", "status after sweep", v, 8'h03);
        wr(A_CMD, 8'h08);
        peek(A_STAT, v); check("R10", "overrun status cleared", v, 8'h01);

        // R9 release
        pulse(1'b1, 1'b0, 1'b0);
        wr(A_CMD, 8'h04);
        peek(A_INTR, v); check("R9", "release pending0 flags", v, 8'h01);
        peek(A_STAT, v); check("R9", "release pending0 status", v, 8'h01);
        rx_pending = 2;
        wr(A_CMD, 8'h04);
        peek(A_INTR, v); check("R9", "release pending2 flags", v, 8'h01);
        rx_pending = 1;
        wr(A_CMD, 8'h04);
        peek(A_INTR, v); check("R9", "release last flags", v, 8'h00);
        peek(A_STAT, v); check("R9", "release last status", v, 8'h00);
        rx_pending = 0;

        // R10
        pulse(1'b0, 1'b0, 1'b1);
        peek(A_INTR, v); check("R8", "overrun flag", v, 8'h08);
        peek(A_STAT, v); check("R8", "overrun status", v, 8'h02);
        wr(A_CMD, 8'h08);
        peek(A_INTR, v); check("R10", "overrun flag cleared", v, 8'h00);
        peek(A_STAT, v); check("R10", "overrun status cleared", v, 8'h00);

        // R11 read-clear with pending messages
        pulse(1'b0, 1'b1, 1'b0);
        rx_pending = 3;
        rdclr(v); check("R11", "read value", v, 8'h02);
        peek(A_INTR, v); check("R11", "rx refilled", v, 8'h01);
        rx_pending = 0;
        rdclr(v); check("R11", "second read value", v, 8'h01);
        peek(A_INTR, v); check("R11", "cleared when none pending", v, 8'h00);

        // R12 collisions
        bus_addr = ADDR_W'(A_INTR); bus_rd = 1'b1; ev_tx = 1'b1;
        @(negedge clk); bus_rd = 1'b0; ev_tx = 1'b0;
        peek(A_INTR, v); check("R12", "read vs tx", v, 8'h02);
        bus_addr = ADDR_W'(A_INTR); bus_rd = 1'b1; ev_rx = 1'b1;
        @(negedge clk); bus_rd = 1'b0; ev_rx = 1'b0;
        peek(A_INTR, v); check("R12", "read vs rx", v, 8'h01);
        rdclr(v);
        ev_ovr = 1'b1; wr(A_CMD, 8'h08); ev_ovr = 1'b0;
        peek(A_INTR, v); check("R12", "clear vs overrun", v, 8'h08);
        rdclr(v);

        // R5 enable write changes irq one cycle later
        wr(A_IEN, 8'h00);
        pulse(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R3", "irq masked", {7'b0, irq}, 8'h00);
        wr(A_IEN, 8'h01);
        check("R5", "irq lags enable write", {7'b0, irq}, 8'h00);
        @(negedge clk);
        check("R5", "irq after enable write", {7'b0, irq}, 8'h01);
        rdclr(v);
        @(negedge clk);
        check("R5", "irq low after clear", {7'b0, irq}, 8'h00);

        // R2 bank separation
        pulse(1'b0, 1'b1, 1'b0);
        wr(A_CDIV, 8'h00);
        peek(A_INTR, v); check("R2", "basic bank kept", v, 8'h0b);
        rdclr(v);
        peek(A_INTR, v); check("R2", "basic bank cleared", v, 8'h00);
        wr(A_CTRL, 8'h16);
        pulse(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R4", "basic irq rx", {7'b0, irq}, 8'h01);
        wr(A_CDIV, 8'h80);
        peek(A_INTR, v); check("R2", "extended bank kept", v, 8'h02);
        @(negedge clk);
        check("R2", "irq follows extended enables", {7'b0, irq}, 8'h00);
        wr(A_CDIV, 8'h00);
        peek(A_INTR, v); check("R2", "basic bank back", v, 8'h01);
        @(negedge clk);
        check("R2", "irq follows basic enables", {7'b0, irq}, 8'h01);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule